// File: doc/BRIEF.md
# Serial Audio Frame Receiver

This block receives a two-channel serial audio stream as a slave and turns each sample frame into a pair of parallel words. Its clock is the incoming bit clock. On every rising edge it samples the word/frame clock and the data line. A level change, or a rising edge in DSP framing, marks where a channel word or a frame begins.

Two framings are supported, chosen by `dsp_fmt_i`. In I2S framing the word clock is low for the left channel and high for the right channel. In DSP framing a short or long pulse starts the frame, and the right word follows the left word directly. In DSP framing `dsp_early_i` picks how far the first data bit sits behind the frame pulse. A 2-bit code selects the word length. Each word comes out left-aligned in a 32-bit field.

A complete frame appears on `left_o`/`right_o` with a single-cycle `valid_o`. The framing-error flag `frm_err_o` reports a start that arrives in the middle of a word. The receiver then drops the incomplete frame and locks onto the new start.

Top module: `aud_frame_rx`

## Requirements
- R1: While `rst_i` is high, `valid_o` and `frm_err_o` are 0 and `left_o` and `right_o` are all zeros.
- R2: With `dsp_fmt_i`=0 (I2S), any change of `frame_i` starts a channel word: a change to 0 starts the left word, a change to 1 the right word. The first data bit is sampled on the rising edge after the one that saw the change.
- R3: Words arrive MSB first and occupy n consecutive bit clocks. n is 16, 20, 24 or 32 for `wlen_i` = 0, 1, 2 or 3. The word is output left-aligned in 32 bits, and the 32-n low bits are zero.
- R4: With `dsp_fmt_i`=1, a frame starts on the rising edge that first samples `frame_i` high after a low sample. With `dsp_early_i`=0 the left MSB is taken on the next rising edge. With `dsp_early_i`=1 it is taken on that same edge.
- R5: In DSP framing the right-channel MSB is sampled on the edge right after the left-channel LSB.
- R6: Bit clocks outside the n-bit words, such as the padding in a channel slot or the spare clocks before the next frame, do not affect any output.
- R7: In DSP framing the frame pulse may be any width from one bit clock up to two less than the frame length.
- R8: `valid_o` is high for exactly one cycle: the cycle after the edge that sampled the right-channel LSB of a frame whose left word was also received. `left_o` and `right_o` change only in that cycle.
- R9: A start that arrives while a word is still being captured raises `frm_err_o` for one cycle, in the cycle after that edge. The incomplete frame is never presented, and capture restarts from the new start.
- R10: A word whose LSB falls on the same edge as the next start is complete and raises no error. This applies in I2S framing and in DSP framing with `dsp_early_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; every register is clocked by its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Word clock (I2S) or frame pulse (DSP) |
| sdata_i | input | 1 | Serial data |
| dsp_fmt_i | input | 1 | 0: I2S framing, 1: DSP framing |
| dsp_early_i | input | 1 | DSP only: 0 MSB one bit clock after the start, 1 MSB on the start edge |
| wlen_i | input | 2 | Word length code (16/20/24/32 bits) |
| left_o | output | 32 | Left sample, left-aligned |
| right_o | output | 32 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| frm_err_o | output | 1 | One-cycle framing-error strobe |

## Verification
Both strobes are registered. `valid_o` is due in the cycle after the edge that sampled the right LSB. `frm_err_o` is due in the cycle after the edge that saw the early start. The bench builds the serial stream edge by edge and records the edge index at which each result is due. The monitor samples on falling edges and computes which edge has just been taken, then compares that index, along with both sample words, against the queued entry.

// File: rtl/aud_frame_rx_pkg.sv
package aud_frame_rx_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // Word length code to bit count
  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/aud_frame_detect.sv
module aud_frame_detect
  import aud_frame_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  frame_i,
  input  logic  dsp_fmt_i,
  output logic  start_o,
  output chan_e start_chan_o
);

  logic frame_q;
  logic primed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      frame_q  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      frame_q  <= frame_i;
      primed_q <= 1'b1;
    end
  end

  // The first sample after reset only primes the history register
  always_comb begin
    if (dsp_fmt_i) begin
      start_o      = primed_q && frame_i && !frame_q;
      start_chan_o = CH_LEFT;
    end else begin
      start_o      = primed_q && (frame_i != frame_q);
      start_chan_o = chan_e'(frame_i);
    end
  end

endmodule

// File: rtl/aud_word_capture.sv
module aud_word_capture
  import aud_frame_rx_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                sdata_i,
  input  logic                dsp_fmt_i,
  input  logic                dsp_early_i,
  input  logic [1:0]          wlen_i,
  input  logic                start_i,
  input  chan_e               start_chan_i,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                done_left_o,
  output logic                done_right_o,
  output logic                err_o
);

  logic                active_q;
  chan_e               chan_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SAMPLE_W-1:0] sreg_q;

  logic [CNT_W-1:0]    wl;
  logic [SAMPLE_W-1:0] shifted;
  logic                no_delay;
  logic                finishing;
  logic                legit_overlap;

  always_comb begin
    wl            = CNT_W'(word_bits(wlen_i));
    no_delay      = dsp_fmt_i && dsp_early_i;
    shifted       = {sreg_q[SAMPLE_W-2:0], sdata_i};
    finishing     = active_q && (cnt_q == wl - CNT_W'(1));
    legit_overlap = finishing && !no_delay && (!dsp_fmt_i || chan_q == CH_RIGHT);
    err_o         = start_i && active_q && !legit_overlap;
    done_left_o   = finishing && (chan_q == CH_LEFT) && !err_o;
    done_right_o  = finishing && (chan_q == CH_RIGHT) && !err_o;
    word_o        = shifted << (CNT_W'(SAMPLE_W) - wl);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      active_q <= 1'b0;
      chan_q   <= CH_LEFT;
      cnt_q    <= '0;
      sreg_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      chan_q   <= start_chan_i;
      if (no_delay) begin
        sreg_q <= shifted;
        cnt_q  <= CNT_W'(1);
      end else begin
        cnt_q  <= '0;
      end
    end else if (active_q) begin
      sreg_q <= shifted;
      if (finishing) begin
        cnt_q <= '0;
        if (dsp_fmt_i && chan_q == CH_LEFT) chan_q <= CH_RIGHT;
        else                                active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    active_q |-> (cnt_q < wl));

endmodule

// File: rtl/aud_frame_rx.sv
module aud_frame_rx
  import aud_frame_rx_pkg::*;
#(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                frame_i,
  input  logic                sdata_i,
  input  logic                dsp_fmt_i,
  input  logic                dsp_early_i,
  input  logic [1:0]          wlen_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                frm_err_o
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic                start;
  chan_e               start_chan;
  logic [SAMPLE_W-1:0] word;
  logic                done_left;
  logic                done_right;
  logic                cap_err;
  logic [SAMPLE_W-1:0] left_hold_q;
  logic                have_left_q;

  aud_frame_detect u_detect (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .frame_i      (frame_i),
    .dsp_fmt_i    (dsp_fmt_i),
    .start_o      (start),
    .start_chan_o (start_chan)
  );

  aud_word_capture #(
    .SAMPLE_W (SAMPLE_W),
    .CNT_W    (CNT_W)
  ) u_capture (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .sdata_i      (sdata_i),
    .dsp_fmt_i    (dsp_fmt_i),
    .dsp_early_i  (dsp_early_i),
    .wlen_i       (wlen_i),
    .start_i      (start),
    .start_chan_i (start_chan),
    .word_o       (word),
    .done_left_o  (done_left),
    .done_right_o (done_right),
    .err_o        (cap_err)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      frm_err_o   <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      frm_err_o <= cap_err;
      if (cap_err) have_left_q <= 1'b0;
      if (done_left) begin
        left_hold_q <= word;
        have_left_q <= 1'b1;
      end
      if (done_right) begin
        have_left_q <= 1'b0;
        if (have_left_q) begin
          left_o  <= left_hold_q;
          right_o <= word;
          valid_o <= 1'b1;
        end
      end
    end
  end

  logic [SAMPLE_W-1:0] low_mask;
  always_comb low_mask = (SAMPLE_W'(1) << (SAMPLE_W - int'(word_bits(wlen_i)))) - SAMPLE_W'(1);

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R9
  err_no_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    frm_err_o |-> !valid_o);

  // R3
  low_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> (((left_o | right_o) & low_mask) == '0));

endmodule

// File: tb/tb_aud_frame_rx.sv
module tb_aud_frame_rx;

  localparam int CLK_PERIOD = 10;
  localparam int STREAM_N   = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_i = 1'b0;
  logic        sdata_i = 1'b0;
  logic        dsp_fmt = 1'b0;
  logic        dsp_early = 1'b0;
  logic [1:0]  wlen = 2'd0;
  logic [31:0] left_o, right_o;
  logic        valid_o, frm_err_o;

  aud_frame_rx dut (
    .clk_i       (clk),
    .rst_i       (rst),
    .frame_i     (frame_i),
    .sdata_i     (sdata_i),
    .dsp_fmt_i   (dsp_fmt),
    .dsp_early_i (dsp_early),
    .wlen_i      (wlen),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o),
    .frm_err_o   (frm_err_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  int base  = 0;
  string seg_tag = "R1";

  logic ws_s [STREAM_N];
  logic sd_s [STREAM_N];

  logic [31:0] exp_l [$];
  logic [31:0] exp_r [$];
  int          exp_e [$];
  int          err_e [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] align(input logic [31:0] v, input int n);
    return v << (32 - n);
  endfunction

  task automatic clear_stream(input logic idle_ws);
    for (int i = 0; i < STREAM_N; i++) begin
      ws_s[i] = idle_ws;
      sd_s[i] = i[0] ^ i[2];
    end
  endtask

  // R2: left word bits at s+1.., right word bits at s+hl+1..
  task automatic i2s_frame(input int s, input int hl, input int hr, input int n,
                           input logic [31:0] l, input logic [31:0] r, input bit good);
    for (int i = 0; i < hl + hr; i++) ws_s[s + i] = (i >= hl);
    for (int j = 0; j < n; j++) sd_s[s + 1 + j] = l[n - 1 - j];
    for (int j = 0; j < n; j++) sd_s[s + hl + 1 + j] = r[n - 1 - j];
    if (good) begin
      exp_l.push_back(align(l, n));
      exp_r.push_back(align(r, n));
      exp_e.push_back(s + hl + n);
    end
  endtask

  // R4/R5: delay 0 (early) or 1, right follows left directly
  task automatic dsp_frame(input int s, input int f, input int p, input int n, input bit early,
                           input logic [31:0] l, input logic [31:0] r, input bit good);
    int d;
    d = early ? 0 : 1;
    for (int i = 0; i < f; i++) ws_s[s + i] = (i < p);
    for (int j = 0; j < n; j++) sd_s[s + d + j] = l[n - 1 - j];
    for (int j = 0; j < n; j++) sd_s[s + d + n + j] = r[n - 1 - j];
    if (good) begin
      exp_l.push_back(align(l, n));
      exp_r.push_back(align(r, n));
      exp_e.push_back(s + d + 2 * n - 1);
    end
  endtask

  task automatic play(input int len, input logic fmt, input logic early, input logic [1:0] wl);
    @(negedge clk);
    rst = 1'b1;
    dsp_fmt = fmt;
    dsp_early = early;
    wlen = wl;
    frame_i = ws_s[0];
    sdata_i = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(valid_o == 1'b0, "R1 valid", 64'(valid_o), 64'd0);
    chk(frm_err_o == 1'b0, "R1 err", 64'(frm_err_o), 64'd0);
    chk(left_o == 32'd0, "R1 left", 64'(left_o), 64'd0);
    chk(right_o == 32'd0, "R1 right", 64'(right_o), 64'd0);
    rst = 1'b0;
    base = cyc;
    frame_i = ws_s[0];
    sdata_i = sd_s[0];
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      frame_i = ws_s[i];
      sdata_i = sd_s[i];
    end
    repeat (6) @(negedge clk);
    chk(exp_e.size() == 0, {seg_tag, " missing pairs"}, 64'(exp_e.size()), 64'd0);
    chk(err_e.size() == 0, {seg_tag, " missing errors"}, 64'(err_e.size()), 64'd0);
    exp_l.delete();
    exp_r.delete();
    exp_e.delete();
    err_e.delete();
  endtask

  // Monitor: pops expectations as results appear
  always @(negedge clk) begin
    int idx;
    idx = cyc - base - 1;
    if (!rst && valid_o) begin
      if (exp_e.size() == 0) begin
        chk(1'b0, {seg_tag, " R8 unexpected pair"}, 64'(idx), 64'(-1));
      end else begin
        chk(left_o == exp_l[0], {seg_tag, " R3 left"}, 64'(left_o), 64'(exp_l[0]));
        chk(right_o == exp_r[0], {seg_tag, " R3 right"}, 64'(right_o), 64'(exp_r[0]));
        chk(idx == exp_e[0], {seg_tag, " R8 valid edge"}, 64'(idx), 64'(exp_e[0]));
        void'(exp_l.pop_front());
        void'(exp_r.pop_front());
        void'(exp_e.pop_front());
      end
    end
    if (!rst && frm_err_o) begin
      if (err_e.size() == 0) begin
        chk(1'b0, {seg_tag, " R9 unexpected error"}, 64'(idx), 64'(-1));
      end else begin
        chk(idx == err_e[0], {seg_tag, " R9 error edge"}, 64'(idx), 64'(err_e[0]));
        void'(err_e.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int s;

    // R2 R10: I2S 16-bit, slot equals word, LSB lands on the next change
    seg_tag = "R2/R10";
    clear_stream(1'b1);
    s = 3;
    i2s_frame(s, 16, 16, 16, 32'h1234_A5C3, 32'h0000_7E81, 1'b1); s += 32;
    i2s_frame(s, 16, 16, 16, 32'hFFFF_8001, 32'h5555_FFFF, 1'b1); s += 32;
    i2s_frame(s, 16, 16, 16, 32'h0000_0F0F, 32'h0000_C0DE, 1'b1); s += 32;
    play(s + 4, 1'b0, 1'b0, 2'd0);

    // R6 R3: I2S 24-bit words in 28-clock slots
    seg_tag = "R6/R3";
    clear_stream(1'b1);
    s = 3;
    i2s_frame(s, 28, 28, 24, 32'hAB_9C3D7E, 32'h12_800001, 1'b1); s += 56;
    i2s_frame(s, 28, 28, 24, 32'h00_FFFFFF, 32'h00_5A5A5A, 1'b1); s += 56;
    play(s + 4, 1'b0, 1'b0, 2'd2);

    // R9: I2S 16-bit with a left slot that is cut short
    seg_tag = "R9 i2s";
    clear_stream(1'b1);
    s = 3;
    i2s_frame(s, 16, 16, 16, 32'h0000_1111, 32'h0000_2222, 1'b1); s += 32;
    i2s_frame(s, 10, 16, 16, 32'h0000_3333, 32'h0000_4444, 1'b0);
    err_e.push_back(s + 10); s += 26;
    i2s_frame(s, 16, 16, 16, 32'h0000_5555, 32'h0000_6666, 1'b1); s += 32;
    play(s + 4, 1'b0, 1'b0, 2'd0);

    // R4 R5 R7 R10: DSP delay one, 20-bit, frame exactly two words, one-clock pulse
    seg_tag = "R4/R5/R10";
    clear_stream(1'b0);
    s = 2;
    dsp_frame(s, 40, 1, 20, 1'b0, 32'h000A_BCDE, 32'h0003_0F01, 1'b1); s += 40;
    dsp_frame(s, 40, 1, 20, 1'b0, 32'h000F_FFFF, 32'h0008_0000, 1'b1); s += 40;
    dsp_frame(s, 40, 1, 20, 1'b0, 32'h0005_5555, 32'h000A_AAAA, 1'b1); s += 40;
    play(s + 4, 1'b1, 1'b0, 2'd1);

    // R4 R6 R7: DSP delay zero, 32-bit, wide pulse and spare clocks
    seg_tag = "R4/R6/R7";
    clear_stream(1'b0);
    s = 2;
    dsp_frame(s, 70, 30, 32, 1'b1, 32'hDEAD_BEEF, 32'h8000_0001, 1'b1); s += 70;
    dsp_frame(s, 70, 68, 32, 1'b1, 32'h0123_4567, 32'hFEDC_BA98, 1'b1); s += 70;
    play(s + 4, 1'b1, 1'b1, 2'd3);

    // R9: DSP delay zero, a frame too short for both words
    seg_tag = "R9 dsp";
    clear_stream(1'b0);
    s = 2;
    dsp_frame(s, 40, 3, 16, 1'b1, 32'h0000_ABCD, 32'h0000_1357, 1'b1); s += 40;
    dsp_frame(s, 20, 3, 16, 1'b1, 32'h0000_2468, 32'h0000_9999, 1'b0);
    err_e.push_back(s + 20); s += 20;
    dsp_frame(s, 40, 3, 16, 1'b1, 32'h0000_F00D, 32'h0000_0BAD, 1'b1); s += 40;
    play(s + 4, 1'b1, 1'b1, 2'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule